// File: doc/BRIEF.md
# PWM Time-Base Tick Generator

This block turns one master clock into the timing enables for a multi-channel PWM controller. A free-running 10-bit prescaler counter produces eleven power-of-two tick enables. These are the master rate divided by 1, 2, 4, up to 1024. Two independent linear dividers, A and B, each pick one of those ticks with a 4-bit select field and divide it by an 8-bit integer from 1 to 255. The results are the slower enables `clk_a_o` and `clk_b_o`. Every output is a single-cycle enable pulse on the master clock, not a derived clock, so all PWM channels stay in one clock domain.

The select and divide fields arrive as plain inputs from a configuration register that lives outside this block. That register clears them on reset. A zero divide value, or a select value that names no tap, switches the matching divider off. Any change of a divider's fields restarts its count, so a new setting takes effect from a known phase. Each divider is a small state machine with two states. `DV_IDLE` means the divider is off and its count is held at zero. `DV_COUNT` means the divider counts the selected ticks. The ENABLE transition goes from `DV_IDLE` to `DV_COUNT` and is taken when the divide value is non-zero and the select value is below 11. The DISABLE transition goes from `DV_COUNT` to `DV_IDLE` and is taken when either condition fails.

Top module: `pwm_tick_gen`

## Requirements
- R1: While `rst` is high, every output is low. The dividers' field history is cleared, so the first enabled cycle after reset acts as a field change (R8).
- R2: `tap_o[0]` is high on every cycle where `en` is high and `rst` is low.
- R3: Bit k of `tap_o` (k = 1..10) is a one-cycle pulse. It is high when the low k bits of the prescaler counter are all ones. The counter is 0 on the first enabled cycle after reset, so tap k first fires on enabled cycle 2^k−1 and then every 2^k enabled cycles. Whenever tap k is high, tap k−1 is high as well.
- R4: While `en` is low, all outputs are low and the prescaler counter holds its value. It resumes from that value when `en` returns.
- R5: When `div_a` = D (D from 1 to 255) and `sel_a` = s (s from 0 to 10), `clk_a_o` pulses on every D-th high cycle of `tap_o[s]`. This gives a steady period of D·2^s cycles, and each pulse coincides with a pulse of `tap_o[s]`.
- R6: When `div_a` (or `div_b`) is 0, `clk_a_o` (or `clk_b_o`) stays low.
- R7: When `sel_a` (or `sel_b`) is 11 to 15, the matching divider output stays low.
- R8: On a cycle where a divider's select or divide input differs from its value on the previous cycle, that divider gives no pulse and does not count the tick. Its first pulse comes on the D-th selected tick after that cycle.
- R9: Divider B behaves as in R5 to R8 with `sel_b`/`div_b`, independently of divider A's settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Master clock enable |
| sel_a | input | 4 | Tap select for divider A (0..10 valid) |
| div_a | input | 8 | Divide value for divider A (0 = off) |
| sel_b | input | 4 | Tap select for divider B (0..10 valid) |
| div_b | input | 8 | Divide value for divider B (0 = off) |
| tap_o | output | 11 | Prescaler enables; bit k fires every 2^k enabled cycles |
| clk_a_o | output | 1 | Divider A enable pulse |
| clk_b_o | output | 1 | Divider B enable pulse |

## Verification
A corrupted prescaler counter shows up at once as a broken tap nesting, or as a shifted first-pulse cycle for some tap. A wrong count shows within 2^k cycles on tap k. A stuck or mis-sized divider count gives a wrong spacing between two consecutive `clk_a_o` or `clk_b_o` pulses, which appears within one programmed period. A missed restart appears on the first pulse after a field change. The bench times tap periods, times divider periods over a set of select/divide pairs, and counts the cycles from each field change to the following pulse.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    // Linear divider control states
    typedef enum logic [0:0] {
        DV_IDLE  = 1'b0,   // divider switched off, count held at zero
        DV_COUNT = 1'b1    // counting selected prescaler ticks
    } div_state_e;

    // Number of dividers behind the prescaler
    localparam int NUM_DIVIDERS = 2;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int NTAPS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [NTAPS-1:0] tap_o
);
    localparam int CW = NTAPS - 1;

    logic [CW-1:0] cnt_q;
    logic          run;

    assign run = en & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tap_o[0] = run;

    for (genvar k = 1; k < NTAPS; k++) begin : g_tap
        assign tap_o[k] = run & (&cnt_q[k-1:0]);
    end

endmodule

// File: rtl/pwm_tap_mux.sv
module pwm_tap_mux #(
    parameter int NTAPS = 11,
    parameter int SEL_W = 4
) (
    input  logic [NTAPS-1:0] taps_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o,
    output logic             sel_ok_o
);
    always_comb begin
        tick_o   = 1'b0;
        sel_ok_o = 1'b0;
        for (int i = 0; i < NTAPS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                tick_o   = taps_i[i];
                sel_ok_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_lin_divider.sv
module pwm_lin_divider
    import pwm_tick_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             sel_ok_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pulse_o
);
    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] prev_div_q;
    logic [SEL_W-1:0] prev_sel_q;
    logic             changed;
    logic             active;
    logic             hit;

    assign changed = (div_i != prev_div_q) || (sel_i != prev_sel_q);
    assign active  = sel_ok_i && (div_i != '0);
    assign hit     = (cnt_q == DIV_W'(div_i - 1'b1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= DV_IDLE;
            prev_div_q <= '0;
            prev_sel_q <= '0;
        end else begin
            state_q    <= state_d;
            prev_div_q <= div_i;
            prev_sel_q <= sel_i;
        end
    end

    // next state: ENABLE and DISABLE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE:  if (active)  state_d = DV_COUNT;
            DV_COUNT: if (!active) state_d = DV_IDLE;
            default:  state_d = DV_IDLE;
        endcase
    end

    // tick counter
    always_ff @(posedge clk) begin
        if (rst || changed || state_q == DV_IDLE) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            DV_IDLE:  pulse_o = 1'b0;
            DV_COUNT: pulse_o = active && !changed && tick_i && hit;
            default:  pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int NTAPS = 11,
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [DIV_W-1:0] div_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic [DIV_W-1:0] div_b,
    output logic [NTAPS-1:0] tap_o,
    output logic             clk_a_o,
    output logic             clk_b_o
);
    logic [NUM_DIVIDERS-1:0][SEL_W-1:0] sel_v;
    logic [NUM_DIVIDERS-1:0][DIV_W-1:0] div_v;
    logic [NUM_DIVIDERS-1:0]            tick_v;
    logic [NUM_DIVIDERS-1:0]            ok_v;
    logic [NUM_DIVIDERS-1:0]            pulse_v;

    assign sel_v = {sel_b, sel_a};
    assign div_v = {div_b, div_a};

    pwm_prescaler #(.NTAPS(NTAPS)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .tap_o (tap_o)
    );

    for (genvar d = 0; d < NUM_DIVIDERS; d++) begin : g_div
        pwm_tap_mux #(.NTAPS(NTAPS), .SEL_W(SEL_W)) u_mux (
            .taps_i   (tap_o),
            .sel_i    (sel_v[d]),
            .tick_o   (tick_v[d]),
            .sel_ok_o (ok_v[d])
        );

        pwm_lin_divider #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (tick_v[d]),
            .sel_ok_i (ok_v[d]),
            .sel_i    (sel_v[d]),
            .div_i    (div_v[d]),
            .pulse_o  (pulse_v[d])
        );
    end

    assign clk_a_o = pulse_v[0];
    assign clk_b_o = pulse_v[1];
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
    parameter int NTAPS = 11,
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [SEL_W-1:0] sel_a,
    input logic [DIV_W-1:0] div_a,
    input logic [SEL_W-1:0] sel_b,
    input logic [DIV_W-1:0] div_b,
    input logic [NTAPS-1:0] tap_o,
    input logic             clk_a_o,
    input logic             clk_b_o
);
    AST_RESET_SILENT: assert property (@(posedge clk)
        rst |-> (tap_o == '0 && !clk_a_o && !clk_b_o)); // R1

    AST_TAP0_WITH_EN: assert property (@(posedge clk) disable iff (rst)
        en |-> tap_o[0]); // R2

    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
        (tap_o[NTAPS-1:1] & ~tap_o[NTAPS-2:0]) == '0); // R3

    AST_TAP1_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tap_o[1] |=> !tap_o[1]); // R3

    AST_EN_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en |-> (tap_o == '0 && !clk_a_o && !clk_b_o)); // R4

    AST_CLKA_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        clk_a_o |-> (|((tap_o >> sel_a) & NTAPS'(1)))); // R5

    AST_DIV_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        (div_a == '0) |-> !clk_a_o); // R6

    AST_BAD_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
        (sel_a >= SEL_W'(NTAPS)) |-> !clk_a_o); // R7

    AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (div_a != $past(div_a) || sel_a != $past(sel_a)) |-> !clk_a_o); // R8

    AST_CLKB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        clk_b_o |-> ((div_b != '0) && (|((tap_o >> sel_b) & NTAPS'(1))))); // R9
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
    .NTAPS(NTAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .en(en),
    .sel_a(sel_a), .div_a(div_a), .sel_b(sel_b), .div_b(div_b),
    .tap_o(tap_o), .clk_a_o(clk_a_o), .clk_b_o(clk_b_o)
);

// File: tb/pwm_tick_gen_tb.sv
module pwm_tick_gen_tb;
    localparam int NT = 11;

    typedef struct packed {
        logic [3:0]  sa;
        logic [7:0]  da;
        logic [3:0]  sb;
        logic [7:0]  db;
        logic [15:0] pa;   // expected period of clk_a_o
        logic [15:0] pb;   // expected period of clk_b_o
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  8'd1,   4'd0, 8'd2,   16'd1,    16'd2},
        '{4'd0,  8'd7,   4'd1, 8'd3,   16'd7,    16'd6},
        '{4'd3,  8'd5,   4'd2, 8'd1,   16'd40,   16'd4},
        '{4'd10, 8'd2,   4'd4, 8'd9,   16'd2048, 16'd144},
        '{4'd5,  8'd255, 4'd0, 8'd255, 16'd8160, 16'd255},
        '{4'd7,  8'd3,   4'd6, 8'd11,  16'd384,  16'd704},
        '{4'd1,  8'd1,   4'd9, 8'd1,   16'd2,    16'd512},
        '{4'd8,  8'd4,   4'd3, 8'd17,  16'd1024, 16'd136}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [3:0]    sel_a = '0, sel_b = '0;
    logic [7:0]    div_a = '0, div_b = '0;
    logic [NT-1:0] tap_o;
    logic          clk_a_o, clk_b_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pwm_tick_gen u_dut (
        .clk(clk), .rst(rst), .en(en),
        .sel_a(sel_a), .div_a(div_a), .sel_b(sel_b), .div_b(div_b),
        .tap_o(tap_o), .clk_a_o(clk_a_o), .clk_b_o(clk_b_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance to next negedge, then settle
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // cycles until the chosen divider output pulses (-1 on timeout)
    task automatic wait_pulse(input bit which_b, output int n);
        n = 0;
        forever begin
            step();
            n++;
            if ((which_b ? clk_b_o : clk_a_o) == 1'b1) return;
            if (n > 20000) begin
                n = -1;
                return;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step();
        step();
    endtask

    initial begin
        int first [NT];
        int second[NT];
        int n;
        int cnt_a, cnt_b;

        // R1: reset keeps everything silent even with live fields
        en = 1'b1; sel_a = 4'd0; div_a = 8'd1; sel_b = 4'd0; div_b = 8'd1;
        step(); step();
        check("R1 tap_o in reset", int'(tap_o), 0);
        check("R1 clk_a_o in reset", int'(clk_a_o), 0);
        check("R1 clk_b_o in reset", int'(clk_b_o), 0);

        // R1/R8: first enabled cycle after reset is a change cycle
        div_a = 8'd3;
        @(negedge clk); rst = 1'b0; #1;
        check("R2 tap0 first cycle", int'(tap_o[0]), 1);
        check("R1 no pulse on release", int'(clk_a_o), 0);
        wait_pulse(1'b0, n);
        check("R1 first clk_a after reset", n, 3);

        // R3: tap first pulse and spacing
        do_reset();
        sel_a = '0; div_a = '0; sel_b = '0; div_b = '0;
        for (int k = 0; k < NT; k++) begin first[k] = -1; second[k] = -1; end
        @(negedge clk); rst = 1'b0; #1;
        for (int c = 0; c < 2100; c++) begin
            if (c > 0) step();
            for (int k = 0; k < NT; k++) begin
                if (tap_o[k]) begin
                    if (first[k] < 0) first[k] = c;
                    else if (second[k] < 0) second[k] = c;
                end
            end
        end
        for (int k = 0; k < NT; k++) begin
            check($sformatf("R3 tap%0d first", k), first[k], (1 << k) - 1);
            check($sformatf("R3 tap%0d period", k), second[k] - first[k], 1 << k);
        end

        // R4: enable low silences outputs and freezes the counter
        do_reset();
        sel_a = 4'd0; div_a = 8'd1;
        @(negedge clk); rst = 1'b0; #1;       // cnt 0
        for (int i = 1; i < 5; i++) step();   // cnt 4
        step(); // cnt 5 visible; now drop enable
        en = 1'b0; #1;
        cnt_a = 0;
        for (int i = 0; i < 20; i++) begin
            if (tap_o != '0 || clk_a_o) cnt_a++;
            step();
        end
        check("R4 outputs while en low", cnt_a, 0);
        en = 1'b1; #1;                         // cnt still 5
        check("R4 resume taps[2:0]", int'(tap_o[2:0]), 3);
        step(); step();                        // cnt 7
        check("R4 resume taps[3:0]", int'(tap_o[3:0]), 15);

        // R5/R9: table of period vectors
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            sel_a = VEC[v].sa; div_a = VEC[v].da;
            sel_b = VEC[v].sb; div_b = VEC[v].db;
            wait_pulse(1'b0, n);
            wait_pulse(1'b0, n);
            check($sformatf("R5 vec%0d clk_a period", v), n, int'(VEC[v].pa));
            wait_pulse(1'b1, n);
            wait_pulse(1'b1, n);
            check($sformatf("R9 vec%0d clk_b period", v), n, int'(VEC[v].pb));
        end

        // R6/R7: zero divide and invalid select
        @(negedge clk);
        sel_a = 4'd0; div_a = 8'd0; sel_b = 4'd12; div_b = 8'd5;
        cnt_a = 0; cnt_b = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            if (clk_a_o) cnt_a++;
            if (clk_b_o) cnt_b++;
        end
        check("R6 clk_a with div 0", cnt_a, 0);
        check("R7 clk_b with sel 12", cnt_b, 0);
        @(negedge clk); sel_b = 4'd15; div_b = 8'd1;
        cnt_b = 0;
        for (int i = 0; i < 100; i++) begin step(); if (clk_b_o) cnt_b++; end
        check("R7 clk_b with sel 15", cnt_b, 0);

        // R8: divide change restarts count
        @(negedge clk); sel_a = 4'd0; div_a = 8'd10;
        wait_pulse(1'b0, n);
        step(); step(); step();
        div_a = 8'd4; #1;
        check("R8 quiet on change cycle", int'(clk_a_o), 0);
        wait_pulse(1'b0, n);
        check("R8 first pulse after div change", n, 4);

        // R8: select change restarts count, measured in selected ticks
        @(negedge clk); div_a = 8'd3;
        wait_pulse(1'b0, n);
        step();
        sel_a = 4'd1; #1;
        cnt_b = 0; n = 0;
        forever begin
            step();
            n++;
            if (tap_o[1]) cnt_b++;
            if (clk_a_o || n > 100) break;
        end
        check("R8 ticks to pulse after sel change", cnt_b, 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule